// File: doc/BRIEF.md
# Triggered Multi-Buffer Sample Capture

This block is the digital readout core of a multi-channel digitizer front end. On every edge of a free-running sampling clock it stores one sample per channel into a circular pipeline. When a trigger is seen, the block copies a window of consecutive samples from every channel into one of four event buffers. The window starts a programmable number of samples before the trigger, and its length is programmable too. The buffer is tagged with the running event number.

A host programs the latency and window length over a small register port. It then reads the stored words back by choosing a buffer, a channel and a sample index. Reading the last word of the last channel frees the buffer. Triggers that find the next buffer still occupied are dropped and flagged. A test mode overwrites the whole event store with a counter pattern, so that the readout path can be checked without analog input.

The data bus is split into input, output and output-enable at the block edge, ready for a bidirectional pad.

Top module: `trig_capture_core`

## Requirements
- R1: After reset or after a one-cycle `sync` pulse, no buffer is ready, `ovf` and `busy` are 0, the event counter is 0 and the pipeline write position restarts. Reset also sets latency to 0 and window length to 1. `sync` leaves both setup values unchanged.
- R2: For a trigger sampled at clock edge E with latency L, captured word j of channel c equals the channel-c sample presented at edge E-L+j. Channel c occupies bits [c*DW +: DW] of `adc_in`.
- R3: A window of N samples is stored per channel and the buffer shows ready once the copy ends. The buffer is freed by a read strobe on index N-1 of the last channel. Latency and length are latched per trigger.
- R4: Setup values are clamped when written. A latency above MAX_LAT (23) is stored as 23. A length of 0 is stored as 1, and a length above MAX_EVT (8) is stored as 8.
- R5: Accepted triggers fill buffers in round-robin order. Event number n lands in buffer n mod 4, and `evt_tag` shows the event number held by the buffer on `buf_sel`.
- R6: Triggers on consecutive clock edges each fill their own buffer with their own window.
- R7: A trigger whose target buffer is not free is dropped. `busy` is high while the target is occupied, `ovf` is set and stays set until `sync`, and the event counter does not advance.
- R8: While `test_mode` is high, triggers are ignored and event-store location (b*NCH+c)*MAX_EVT+i receives a counter value. The counter starts at 0 on the first test edge and rises by one per edge. After test mode, every buffer is ready with length MAX_EVT and buffer b has tag b.
- R9: `host_oe` is 1 only while `host_cs`, `host_rw`=1 (read) and `host_stb` are all high. At that time `host_dout` carries the word at (`buf_sel`, `ch_sel`, `rd_idx`) in the same cycle.
- R10: With `host_cs`=1, `host_rw`=0 and `host_stb`=1, the value on `host_din` is written at the clock edge: to the latency when `cfg_sel`=0, to the window length when `cfg_sel`=1. With `host_cs`=0 the write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sync | input | 1 | Synchronous restart of pipeline, buffers, event counter and flag |
| adc_in | input | NCH*DW | One sample per channel per clock |
| trigger | input | 1 | Capture request, one per high clock edge |
| test_mode | input | 1 | Fill event store with counter pattern |
| host_cs | input | 1 | Chip enable |
| host_rw | input | 1 | 1 = read, 0 = write |
| host_stb | input | 1 | Access strobe |
| cfg_sel | input | 1 | Setup register select: 0 latency, 1 length |
| buf_sel | input | 2 | Event buffer select |
| ch_sel | input | 1 | Channel select |
| rd_idx | input | 3 | Sample index within the window |
| host_din | input | DW | Write data |
| host_dout | output | DW | Read data |
| host_oe | output | 1 | Read data drive enable |
| evt_tag | output | EVW | Event number of selected buffer |
| buf_ready | output | NBUF | Per-buffer ready (holds unread data) |
| busy | output | 1 | Next target buffer is occupied |
| ovf | output | 1 | Sticky dropped-trigger flag |

## Verification
Each copy starts one edge after the trigger edge and writes one sample per edge, so the buffer is ready after N+1 edges. The bench waits N+3 falling edges before reading. `ovf`, `busy`-driven drops and event counter changes take effect at the trigger edge itself, so they are checked at the following falling edge. Read data, `host_oe` and `evt_tag` are combinational from the select lines and are sampled 1 ns after they are set, well before the next rising edge. A release strobe is held across exactly one rising edge, and readiness is checked at the falling edge after it.

// File: rtl/tcap_pkg.sv
package tcap_pkg;
  typedef enum logic [1:0] {
    BS_FREE = 2'd0,
    BS_CAPT = 2'd1,
    BS_FULL = 2'd2
  } bstate_e;
endpackage

// File: rtl/tcap_pipeline.sv
module tcap_pipeline #(
  parameter int NCH  = 2,
  parameter int DW   = 8,
  parameter int PD   = 32,
  parameter int NBUF = 4,
  localparam int PW  = $clog2(PD)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sync,
  input  logic [NCH*DW-1:0]      din,
  input  logic [NBUF*PW-1:0]     raddr,
  output logic [PW-1:0]          wptr,
  output logic [NBUF*NCH*DW-1:0] rdata
);
  logic [DW-1:0] mem [NCH][PD];
  logic [PW-1:0] wptr_d, wptr_q;

  always_comb begin
    wptr_d = sync ? '0 : wptr_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wptr_q <= '0;
    else        wptr_q <= wptr_d;
  end

  always_ff @(posedge clk) begin
    for (int c = 0; c < NCH; c++) mem[c][wptr_q] <= din[c*DW +: DW];
  end

  for (genvar b = 0; b < NBUF; b++) begin : g_rport
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      assign rdata[(b*NCH+c)*DW +: DW] = mem[c][raddr[b*PW +: PW]];
    end
  end

  assign wptr = wptr_q;

  AST_WPTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !sync |=> wptr_q == $past(wptr_q) + PW'(1)); // R2
  AST_WPTR_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    sync |=> wptr_q == '0); // R1
endmodule

// File: rtl/tcap_buf_engine.sv
module tcap_buf_engine import tcap_pkg::*; #(
  parameter int IDX     = 0,
  parameter int PW      = 5,
  parameter int EW      = 4,
  parameter int IW      = 3,
  parameter int EVW     = 8,
  parameter int MAX_EVT = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sync,
  input  logic           test_mode,
  input  logic           start,
  input  logic [PW-1:0]  start_addr,
  input  logic [EW-1:0]  size_in,
  input  logic [EVW-1:0] tag_in,
  input  logic           release_i,
  output bstate_e        state_o,
  output logic [PW-1:0]  raddr_o,
  output logic           wr_en_o,
  output logic [IW-1:0]  wr_idx_o,
  output logic [EW-1:0]  size_o,
  output logic [EVW-1:0] tag_o
);
  bstate_e        st_d, st_q;
  logic [PW-1:0]  src_d, src_q;
  logic [EW-1:0]  cnt_d, cnt_q;
  logic [EW-1:0]  size_d, size_q;
  logic [EVW-1:0] tag_d, tag_q;

  always_comb begin
    st_d   = st_q;
    src_d  = src_q;
    cnt_d  = cnt_q;
    size_d = size_q;
    tag_d  = tag_q;
    if (sync) begin
      st_d  = BS_FREE;
      cnt_d = '0;
    end else if (test_mode) begin
      st_d   = BS_FULL;
      cnt_d  = '0;
      size_d = EW'(MAX_EVT);
      tag_d  = EVW'(IDX);
    end else begin
      unique case (st_q)
        BS_FREE: if (start) begin
          st_d   = BS_CAPT;
          src_d  = start_addr;
          cnt_d  = '0;
          size_d = size_in;
          tag_d  = tag_in;
        end
        BS_CAPT: begin
          if (cnt_q == size_q - EW'(1)) begin
            st_d  = BS_FULL;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + EW'(1);
          end
        end
        BS_FULL: if (release_i) st_d = BS_FREE;
        default: st_d = BS_FREE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= BS_FREE;
      src_q  <= '0;
      cnt_q  <= '0;
      size_q <= EW'(1);
      tag_q  <= '0;
    end else begin
      st_q   <= st_d;
      src_q  <= src_d;
      cnt_q  <= cnt_d;
      size_q <= size_d;
      tag_q  <= tag_d;
    end
  end

  assign state_o  = st_q;
  assign raddr_o  = src_q + PW'(cnt_q);
  assign wr_en_o  = (st_q == BS_CAPT) && !sync && !test_mode;
  assign wr_idx_o = cnt_q[IW-1:0];
  assign size_o   = size_q;
  assign tag_o    = tag_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == BS_CAPT |-> cnt_q < size_q); // R3
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == BS_FULL && !release_i && !sync && !test_mode) |=> st_q == BS_FULL); // R3
  AST_SIZE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    st_q != BS_FREE |-> (size_q >= EW'(1) && size_q <= EW'(MAX_EVT))); // R4
endmodule

// File: rtl/tcap_event_ram.sv
module tcap_event_ram #(
  parameter int NBUF    = 4,
  parameter int NCH     = 2,
  parameter int DW      = 8,
  parameter int MAX_EVT = 8,
  localparam int DEPTH  = NBUF*NCH*MAX_EVT,
  localparam int AW     = $clog2(DEPTH),
  localparam int IW     = $clog2(MAX_EVT),
  localparam int BW     = $clog2(NBUF),
  localparam int CW     = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                   clk,
  input  logic [NBUF-1:0]        eng_we,
  input  logic [NBUF*IW-1:0]     eng_idx,
  input  logic [NBUF*NCH*DW-1:0] eng_data,
  input  logic                   tst_we,
  input  logic [AW-1:0]          tst_addr,
  input  logic [DW-1:0]          tst_data,
  input  logic [BW-1:0]          rd_buf,
  input  logic [CW-1:0]          rd_ch,
  input  logic [IW-1:0]          rd_idx,
  output logic [DW-1:0]          rd_data
);
  logic [DW-1:0] ram [DEPTH];
  logic [AW-1:0] rd_loc;

  always_ff @(posedge clk) begin
    for (int b = 0; b < NBUF; b++) begin
      if (eng_we[b]) begin
        for (int c = 0; c < NCH; c++) begin
          ram[(b*NCH+c)*MAX_EVT + int'(eng_idx[b*IW +: IW])] <= eng_data[(b*NCH+c)*DW +: DW];
        end
      end
    end
    if (tst_we) ram[tst_addr] <= tst_data;
  end

  always_comb begin
    rd_loc  = AW'((int'(rd_buf)*NCH + int'(rd_ch))*MAX_EVT + int'(rd_idx));
    rd_data = (int'(rd_ch) < NCH) ? ram[rd_loc] : '0;
  end
endmodule

// File: rtl/trig_capture_core.sv
module trig_capture_core import tcap_pkg::*; #(
  parameter int NCH     = 2,
  parameter int DW      = 8,
  parameter int NBUF    = 4,
  parameter int MAX_EVT = 8,
  parameter int MAX_LAT = 23,
  parameter int PD      = 32,
  parameter int EVW     = 8,
  localparam int PW     = $clog2(PD),
  localparam int LW     = $clog2(MAX_LAT+1),
  localparam int EW     = $clog2(MAX_EVT+1),
  localparam int IW     = $clog2(MAX_EVT),
  localparam int BW     = $clog2(NBUF),
  localparam int CW     = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int TOT    = NBUF*NCH*MAX_EVT,
  localparam int AW     = $clog2(TOT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync,
  input  logic [NCH*DW-1:0] adc_in,
  input  logic              trigger,
  input  logic              test_mode,
  input  logic              host_cs,
  input  logic              host_rw,
  input  logic              host_stb,
  input  logic              cfg_sel,
  input  logic [BW-1:0]     buf_sel,
  input  logic [CW-1:0]     ch_sel,
  input  logic [IW-1:0]     rd_idx,
  input  logic [DW-1:0]     host_din,
  output logic [DW-1:0]     host_dout,
  output logic              host_oe,
  output logic [EVW-1:0]    evt_tag,
  output logic [NBUF-1:0]   buf_ready,
  output logic              busy,
  output logic              ovf
);
  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_s  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_s  <= rst_meta;
    end
  end

  // setup registers
  logic          cfg_wr;
  logic [LW-1:0] lat_d, lat_q;
  logic [EW-1:0] evs_d, evs_q;

  assign cfg_wr = host_cs && !host_rw && host_stb;

  always_comb begin
    lat_d = lat_q;
    evs_d = evs_q;
    if (!cfg_sel) begin
      if (host_din > DW'(MAX_LAT)) lat_d = LW'(MAX_LAT);
      else                         lat_d = LW'(host_din);
    end else begin
      if (host_din == '0)               evs_d = EW'(1);
      else if (host_din > DW'(MAX_EVT)) evs_d = EW'(MAX_EVT);
      else                              evs_d = EW'(host_din);
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      lat_q <= '0;
      evs_q <= EW'(1);
    end else if (cfg_wr) begin
      lat_q <= lat_d;
      evs_q <= evs_d;
    end
  end

  // pipeline
  logic [PW-1:0]          wptr;
  logic [NBUF*PW-1:0]     eng_raddr;
  logic [NBUF*NCH*DW-1:0] pipe_rdata;

  tcap_pipeline #(.NCH(NCH), .DW(DW), .PD(PD), .NBUF(NBUF)) u_pipe (
    .clk(clk), .rst_n(rst_n_s), .sync(sync), .din(adc_in),
    .raddr(eng_raddr), .wptr(wptr), .rdata(pipe_rdata)
  );

  // trigger acceptance and event counter
  bstate_e        eng_st  [NBUF];
  logic [EW-1:0]  eng_size[NBUF];
  logic [EVW-1:0] eng_tag [NBUF];
  logic [NBUF-1:0]    eng_we;
  logic [NBUF*IW-1:0] eng_idx;
  logic [NBUF-1:0]    eng_rel;

  logic [EVW-1:0] evt_d, evt_q;
  logic           ovf_d, ovf_q;
  logic [BW-1:0]  target;
  logic           accept, drop, rd_fire;
  logic [PW-1:0]  start_addr;

  assign target     = evt_q[BW-1:0];
  assign busy       = (eng_st[target] != BS_FREE);
  assign accept     = trigger && !busy && !test_mode && !sync;
  assign drop       = trigger &&  busy && !test_mode && !sync;
  assign start_addr = wptr - PW'(lat_q);
  assign rd_fire    = host_cs && host_rw && host_stb;

  always_comb begin
    evt_d = evt_q;
    ovf_d = ovf_q;
    if (sync) begin
      evt_d = '0;
      ovf_d = 1'b0;
    end else begin
      if (accept) evt_d = evt_q + EVW'(1);
      if (drop)   ovf_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      evt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      evt_q <= evt_d;
      ovf_q <= ovf_d;
    end
  end

  // per-buffer copy engines
  for (genvar i = 0; i < NBUF; i++) begin : g_eng
    logic [PW-1:0] raddr_i;
    logic [IW-1:0] idx_i;
    assign eng_rel[i] = rd_fire && (buf_sel == BW'(i)) && (ch_sel == CW'(NCH-1))
                        && (EW'(rd_idx) == eng_size[i] - EW'(1));
    tcap_buf_engine #(
      .IDX(i), .PW(PW), .EW(EW), .IW(IW), .EVW(EVW), .MAX_EVT(MAX_EVT)
    ) u_eng (
      .clk(clk), .rst_n(rst_n_s), .sync(sync), .test_mode(test_mode),
      .start(accept && (target == BW'(i))), .start_addr(start_addr),
      .size_in(evs_q), .tag_in(evt_q), .release_i(eng_rel[i]),
      .state_o(eng_st[i]), .raddr_o(raddr_i), .wr_en_o(eng_we[i]),
      .wr_idx_o(idx_i), .size_o(eng_size[i]), .tag_o(eng_tag[i])
    );
    assign eng_raddr[i*PW +: PW] = raddr_i;
    assign eng_idx[i*IW +: IW]   = idx_i;
    assign buf_ready[i]          = (eng_st[i] == BS_FULL);
  end

  // test pattern counter
  logic [AW-1:0] tc_d, tc_q;
  always_comb begin
    if (!test_mode)                tc_d = '0;
    else if (tc_q == AW'(TOT - 1)) tc_d = '0;
    else                           tc_d = tc_q + AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) tc_q <= '0;
    else          tc_q <= tc_d;
  end

  // event store
  logic [DW-1:0] ram_word;
  tcap_event_ram #(.NBUF(NBUF), .NCH(NCH), .DW(DW), .MAX_EVT(MAX_EVT)) u_ram (
    .clk(clk), .eng_we(eng_we), .eng_idx(eng_idx), .eng_data(pipe_rdata),
    .tst_we(test_mode), .tst_addr(tc_q), .tst_data(DW'(tc_q)),
    .rd_buf(buf_sel), .rd_ch(ch_sel), .rd_idx(rd_idx), .rd_data(ram_word)
  );

  assign host_oe   = rd_fire;
  assign host_dout = rd_fire ? ram_word : '0;
  assign evt_tag   = eng_tag[buf_sel];
  assign ovf       = ovf_q;

  AST_DROP_FLAG: assert property (@(posedge clk) disable iff (!rst_n_s)
    drop |=> ovf); // R7
  AST_DROP_NOCOUNT: assert property (@(posedge clk) disable iff (!rst_n_s)
    drop |=> evt_q == $past(evt_q)); // R7
  AST_ACCEPT_STEP: assert property (@(posedge clk) disable iff (!rst_n_s)
    accept |=> evt_q == $past(evt_q) + EVW'(1)); // R5
  AST_TEST_FULL: assert property (@(posedge clk) disable iff (!rst_n_s)
    (test_mode && !sync) |=> buf_ready == '1); // R8
  AST_NO_READ_DRIVE: assert property (@(posedge clk) disable iff (!rst_n_s)
    !host_cs |-> !host_oe); // R9
endmodule

// File: tb/sim_trig_capture_core.sv
module sim_trig_capture_core;
  localparam int NCH = 2, DW = 8, NBUF = 4, MAX_EVT = 8, MAX_LAT = 23, EVW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync = 1'b0, trigger = 1'b0, test_mode = 1'b0;
  logic host_cs = 1'b0, host_rw = 1'b0, host_stb = 1'b0, cfg_sel = 1'b0;
  logic [1:0] buf_sel = '0;
  logic [0:0] ch_sel = '0;
  logic [2:0] rd_idx = '0;
  logic [DW-1:0] host_din = '0;
  logic [DW-1:0] host_dout;
  logic host_oe, busy, ovf;
  logic [EVW-1:0] evt_tag;
  logic [NBUF-1:0] buf_ready;
  logic [7:0] seq = '0;
  logic [NCH*DW-1:0] adc_in;

  int checks = 0, errors = 0, evt = 0;

  assign adc_in = {seq + 8'd100, seq};

  always #10 clk = ~clk;
  always @(negedge clk) seq <= seq + 8'd1;

  trig_capture_core u0 (
    .clk(clk), .rst_n(rst_n), .sync(sync), .adc_in(adc_in), .trigger(trigger),
    .test_mode(test_mode), .host_cs(host_cs), .host_rw(host_rw), .host_stb(host_stb),
    .cfg_sel(cfg_sel), .buf_sel(buf_sel), .ch_sel(ch_sel), .rd_idx(rd_idx),
    .host_din(host_din), .host_dout(host_dout), .host_oe(host_oe), .evt_tag(evt_tag),
    .buf_ready(buf_ready), .busy(busy), .ovf(ovf)
  );

  // {latency, length} as written; clamped values computed below
  localparam logic [15:0] VEC [7] = '{16'h0504, 16'h0003, 16'h1708, 16'hC802,
                                      16'h0700, 16'h0332, 16'h0101};

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg(bit sel, int val, bit cs);
    @(negedge clk); #1;
    host_cs = cs; host_rw = 1'b0; host_stb = 1'b1; cfg_sel = sel; host_din = DW'(val);
    @(negedge clk); #1;
    host_cs = 1'b0; host_stb = 1'b0;
  endtask

  task automatic trig(output int t);
    @(negedge clk); #1;
    trigger = 1'b1; t = int'(seq);
    @(negedge clk); #1;
    trigger = 1'b0;
  endtask

  task automatic rdw(int b, int c, int i, output int v, output int oe);
    @(negedge clk); #1;
    host_cs = 1'b1; host_rw = 1'b1; host_stb = 1'b1;
    buf_sel = 2'(b); ch_sel = 1'(c); rd_idx = 3'(i);
    #1; v = int'(host_dout); oe = int'(host_oe);
    #1; host_cs = 1'b0; host_stb = 1'b0;
  endtask

  task automatic rel(int b, int n);
    @(negedge clk); #1;
    host_cs = 1'b1; host_rw = 1'b1; host_stb = 1'b1;
    buf_sel = 2'(b); ch_sel = 1'(NCH-1); rd_idx = 3'(n-1);
    @(negedge clk); #1;
    host_cs = 1'b0; host_stb = 1'b0;
  endtask

  // check a captured window and free it
  task automatic check_win(string req, int b, int t, int lat, int n, int tag);
    int v, oe;
    chk({req, " ready"}, int'(buf_ready[b]), 1);
    buf_sel = 2'(b); #1;
    chk("R5 tag", int'(evt_tag), tag);
    for (int j = 0; j < n; j++) begin
      for (int c = 0; c < NCH; c++) begin
        rdw(b, c, j, v, oe);
        chk({req, " data"}, v, (t - lat + j + c*100) & 255);
        chk("R9 oe on read", oe, 1);
      end
    end
    rel(b, n);
    chk("R3 freed after last read", int'(buf_ready[b]), 0);
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int t, t0, lat, n, b, v, oe;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 ready after reset", int'(buf_ready), 0);
    chk("R1 ovf after reset", int'(ovf), 0);
    chk("R1 busy after reset", int'(busy), 0);
    chk("R1 oe after reset", int'(host_oe), 0);
    repeat (40) @(negedge clk);

    // table walk: latency/length combinations including clamping (R2 R3 R4 R5)
    foreach (VEC[k]) begin
      lat = (int'(VEC[k][15:8]) > MAX_LAT) ? MAX_LAT : int'(VEC[k][15:8]);
      n   = (VEC[k][7:0] == 0) ? 1 : ((int'(VEC[k][7:0]) > MAX_EVT) ? MAX_EVT : int'(VEC[k][7:0]));
      cfg(1'b0, int'(VEC[k][15:8]), 1'b1);  // R10
      cfg(1'b1, int'(VEC[k][7:0]), 1'b1);
      trig(t);
      repeat (n + 3) @(negedge clk);
      #1;
      check_win("R2 R3 R4 vector", evt % NBUF, t, lat, n, evt);
      evt++;
    end

    // R10: write with chip enable low is ignored (latency stays 1, length 1)
    cfg(1'b0, 9, 1'b0);
    trig(t);
    repeat (4) @(negedge clk);
    #1;
    check_win("R10 ignored write", evt % NBUF, t, 1, 1, evt);
    evt++;

    // R6: burst of four triggers on consecutive edges
    cfg(1'b0, 2, 1'b1);
    cfg(1'b1, 3, 1'b1);
    @(negedge clk); #1;
    trigger = 1'b1; t0 = int'(seq);
    repeat (4) @(negedge clk);
    #1 trigger = 1'b0;
    repeat (6) @(negedge clk);
    #1;
    chk("R6 all ready", int'(buf_ready), 15);
    // R7: fifth trigger dropped
    chk("R7 busy", int'(busy), 1);
    trig(t);
    chk("R7 ovf set", int'(ovf), 1);
    for (int k = 0; k < 4; k++) begin
      check_win("R6 burst", (evt + k) % NBUF, t0 + k, 2, 3, evt + k);
    end
    evt += 4;
    chk("R7 ovf sticky", int'(ovf), 1);
    trig(t);
    repeat (6) @(negedge clk);
    #1;
    check_win("R7 count held", evt % NBUF, t, 2, 3, evt);
    evt++;

    // R1: sync restarts buffers, counter and flag
    trig(t);
    @(negedge clk); #1 sync = 1'b1;
    @(negedge clk); #1 sync = 1'b0;
    chk("R1 ready after sync", int'(buf_ready), 0);
    chk("R1 ovf after sync", int'(ovf), 0);
    evt = 0;
    repeat (30) @(negedge clk);
    trig(t);
    repeat (6) @(negedge clk);
    #1;
    check_win("R1 restart", 0, t, 2, 3, 0);

    // R9: no drive without full read access
    @(negedge clk); #1;
    host_cs = 1'b0; host_rw = 1'b1; host_stb = 1'b1; #1;
    chk("R9 oe with cs low", int'(host_oe), 0);
    host_cs = 1'b1; host_stb = 1'b0; #1;
    chk("R9 oe with stb low", int'(host_oe), 0);
    host_cs = 1'b0;

    // R8: test fill for exactly one sweep of the store
    @(negedge clk); #1 test_mode = 1'b1;
    trigger = 1'b1;
    repeat (NBUF*NCH*MAX_EVT) @(negedge clk);
    #1 test_mode = 1'b0; trigger = 1'b0;
    chk("R8 all ready", int'(buf_ready), 15);
    chk("R8 no drop in test", int'(ovf), 0);
    for (b = 0; b < NBUF; b++) begin
      buf_sel = 2'(b); #1;
      chk("R8 tag", int'(evt_tag), b);
      for (int c = 0; c < NCH; c++) begin
        for (int i = 0; i < MAX_EVT; i++) begin
          rdw(b, c, i, v, oe);
          chk("R8 pattern", v, (b*NCH + c)*MAX_EVT + i);
        end
      end
      rel(b, MAX_EVT);
      chk("R8 release", int'(buf_ready[b]), 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule